// File: doc/BRIEF.md
# Hamming SECDED Codec

This block encodes a data word into a Hamming codeword that can correct any single bit error and detect any double bit error. It also decodes such a codeword. The encoder and the decoder share one top module but work independently. The encoder output feeds a storage array or a link. The decoder input takes the word read back from that array or link.

Codeword bits are numbered by position, and position p is bit p of the codeword vector. Even-parity check bits sit at the power-of-two positions. Data bits fill the remaining positions from 3 upward. Bit 0 holds a parity bit over the whole word.

The decoder forms a syndrome, which is the XOR of the positions of all set bits. It checks the syndrome together with the overall parity and reports one of four outcomes:
- a clean word;
- a corrected single error, with its position;
- a flipped position-0 bit;
- an uncorrectable error.

The block is combinational, with an optional output register stage that is on by default.

Top module: `secded_codec`

## Requirements
- R1: With DW data bits, data bit i goes to the i-th position, in ascending order, that is neither 0 nor a power of two. For DW=8 the data positions are 3,5,6,7,9,10,11,12, with data bit 0 at position 3. The codeword is 13 bits wide, and its bit p is position p.
- R2: The check bit at position 2^k makes the XOR of all positions 1..CW-1 whose index has bit k set equal to 0.
- R3: Codeword bit 0 makes the XOR of all CW codeword bits equal to 0.
- R4: A codeword received without error gives back its data, with dec_single_o=0, dec_double_o=0 and dec_pos_o=0.
- R5: A codeword with exactly one flipped bit at position p in 1..CW-1 gives back the original data, with dec_single_o=1, dec_double_o=0 and dec_pos_o=p.
- R6: A codeword in which only bit 0 is flipped gives back the original data, with dec_single_o=1, dec_double_o=0 and dec_pos_o=0.
- R7: When the syndrome is nonzero and the overall parity is good, which covers any two flipped bits, the decoder sets dec_double_o=1, dec_single_o=0 and dec_pos_o=0. It outputs the data bits of the received word unchanged.
- R8: When the overall parity is bad and the syndrome is CW or above, so that no real position exists, the decoder treats the word as uncorrectable. It sets dec_double_o=1, dec_single_o=0 and dec_pos_o=0, and outputs the received data bits unchanged.
- R9: dec_single_o and dec_double_o are never high together. dec_pos_o is 0 whenever dec_single_o is 0.
- R10: With REG_OUT=1, every output shows the result for the inputs sampled at the previous rising clock edge. A synchronous active-high rst drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | DW | Data word to encode |
| enc_code_o | output | CW | Encoded codeword, bit p = position p |
| dec_code_i | input | CW | Received codeword to decode |
| dec_data_o | output | DW | Corrected (or raw, if uncorrectable) data |
| dec_single_o | output | 1 | A single error was found and corrected |
| dec_double_o | output | 1 | An uncorrectable error was found |
| dec_pos_o | output | R | Position that was corrected |

## Verification
The hardest case to reach from the ports is a syndrome that points past the last codeword position while the overall parity is bad. No single or double error can produce it. The bench reaches it with a triple flip of check positions 1, 4 and 8, which gives syndrome 13 with odd parity. Every single-bit position, including bit 0, is also swept against an independently built reference codeword, so each value of the correction mux is exercised.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Smallest number of check bits r such that 2^r >= dw + r + 1
    function automatic int chk_count(input int dw);
        int r;
        r = 0;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Codeword position that carries data bit idx
    function automatic int data_slot(input int idx);
        int n;
        int found;
        n = 0;
        found = 0;
        for (int p = 3; p < 1024; p++) begin
            if (!is_pow2(p)) begin
                if (n == idx && found == 0) found = p;
                n++;
            end
        end
        return found;
    endfunction

    // Data bit index stored at a non power-of-two position p (p >= 3)
    function automatic int slot_bit(input int p);
        int n;
        n = 0;
        for (int q = 3; q < p; q++) begin
            if (!is_pow2(q)) n++;
        end
        return n;
    endfunction

    // Positions 1..cw-1 whose index has bit k set
    function automatic logic [63:0] cover_mask(input int k, input int cw);
        logic [63:0] m;
        m = '0;
        for (int p = 1; p < cw; p++) begin
            if (((p >> k) & 1) == 1) m[p] = 1'b1;
        end
        return m;
    endfunction

    typedef enum logic [1:0] {
        DEC_CLEAN  = 2'd0,
        DEC_FIXED  = 2'd1,
        DEC_DOUBLE = 2'd2
    } dec_kind_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int DW = 8,
    localparam int R  = chk_count(DW),
    localparam int CW = DW + R + 1
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);

    logic [CW-1:0] placed;
    logic [R-1:0]  chk;
    logic [CW-1:0] body;

    // Scatter data into its positions; check and parity positions stay zero
    for (genvar p = 0; p < CW; p++) begin : g_place
        if (p == 0 || is_pow2(p)) begin : g_hole
            assign placed[p] = 1'b0;
        end else begin : g_dat
            assign placed[p] = data_i[slot_bit(p)];
        end
    end

    // Each check bit balances the group it covers
    for (genvar k = 0; k < R; k++) begin : g_chk
        localparam logic [CW-1:0] MASK = CW'(cover_mask(k, CW));
        assign chk[k] = ^(placed & MASK);
    end

    for (genvar p = 0; p < CW; p++) begin : g_body
        if (p == 0) begin : g_zero
            assign body[p] = 1'b0;
        end else if (is_pow2(p)) begin : g_cb
            assign body[p] = chk[$clog2(p)];
        end else begin : g_db
            assign body[p] = placed[p];
        end
    end

    assign code_o = {body[CW-1:1], ^body[CW-1:1]};

endmodule

// File: rtl/secded_syn.sv
module secded_syn
    import secded_pkg::*;
#(
    parameter int DW = 8,
    localparam int R  = chk_count(DW),
    localparam int CW = DW + R + 1
) (
    input  logic [CW-1:0] code_i,
    output logic [R-1:0]  syn_o,
    output logic          par_bad_o
);

    for (genvar k = 0; k < R; k++) begin : g_syn
        localparam logic [CW-1:0] MASK = CW'(cover_mask(k, CW));
        assign syn_o[k] = ^(code_i & MASK);
    end

    assign par_bad_o = ^code_i;

endmodule

// File: rtl/secded_fix.sv
module secded_fix
    import secded_pkg::*;
#(
    parameter int DW = 8,
    localparam int R  = chk_count(DW),
    localparam int CW = DW + R + 1
) (
    input  logic [CW-1:0] code_i,
    input  logic [R-1:0]  syn_i,
    input  logic          par_bad_i,
    output logic [DW-1:0] data_o,
    output logic          single_o,
    output logic          double_o,
    output logic [R-1:0]  pos_o
);

    dec_kind_e     kind;
    logic          in_range;
    logic [CW-1:0] flip;
    logic [CW-1:0] fixed;

    assign in_range = (int'(syn_i) < CW);

    always_comb begin
        if (!par_bad_i) begin
            kind = (syn_i == '0) ? DEC_CLEAN : DEC_DOUBLE;
        end else begin
            kind = in_range ? DEC_FIXED : DEC_DOUBLE;
        end
    end

    always_comb begin
        flip = '0;
        if (kind == DEC_FIXED) flip = CW'(1) << syn_i;
    end

    assign fixed = code_i ^ flip;

    for (genvar i = 0; i < DW; i++) begin : g_pick
        assign data_o[i] = fixed[data_slot(i)];
    end

    assign single_o = (kind == DEC_FIXED);
    assign double_o = (kind == DEC_DOUBLE);
    assign pos_o    = (kind == DEC_FIXED) ? syn_i : '0;

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter int DW      = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int R  = chk_count(DW),
    localparam int CW = DW + R + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] enc_data_i,
    output logic [CW-1:0] enc_code_o,
    input  logic [CW-1:0] dec_code_i,
    output logic [DW-1:0] dec_data_o,
    output logic          dec_single_o,
    output logic          dec_double_o,
    output logic [R-1:0]  dec_pos_o
);

    logic [CW-1:0] enc_c;
    logic [R-1:0]  syn;
    logic          par_bad;
    logic [DW-1:0] fix_data;
    logic          fix_single;
    logic          fix_double;
    logic [R-1:0]  fix_pos;

    secded_enc #(.DW(DW)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_c)
    );

    secded_syn #(.DW(DW)) u_syn (
        .code_i    (dec_code_i),
        .syn_o     (syn),
        .par_bad_o (par_bad)
    );

    secded_fix #(.DW(DW)) u_fix (
        .code_i    (dec_code_i),
        .syn_i     (syn),
        .par_bad_i (par_bad),
        .data_o    (fix_data),
        .single_o  (fix_single),
        .double_o  (fix_double),
        .pos_o     (fix_pos)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                enc_code_o   <= '0;
                dec_data_o   <= '0;
                dec_single_o <= 1'b0;
                dec_double_o <= 1'b0;
                dec_pos_o    <= '0;
            end else begin
                enc_code_o   <= enc_c;
                dec_data_o   <= fix_data;
                dec_single_o <= fix_single;
                dec_double_o <= fix_double;
                dec_pos_o    <= fix_pos;
            end
        end

        // R3: the registered codeword always has even weight
        p_enc_even_r3: assert property (@(posedge clk) disable iff (rst)
            (^enc_code_o) == 1'b0);

        // R9: the two flags never rise together
        p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
            !(dec_single_o && dec_double_o));

        // R9: a position is reported only with a correction
        p_pos_idle_r9: assert property (@(posedge clk) disable iff (rst)
            !dec_single_o |-> dec_pos_o == '0);

        // R5: a corrected position always lies inside the codeword
        p_pos_range_r5: assert property (@(posedge clk) disable iff (rst)
            dec_single_o |-> int'(dec_pos_o) < CW);

        // R10: reset clears every output on the following edge
        p_reset_clear_r10: assert property (@(posedge clk)
            rst |=> (enc_code_o == '0 && dec_data_o == '0 &&
                     !dec_single_o && !dec_double_o && dec_pos_o == '0));

        // R4: a clean input word leaves both flags low one cycle later
        p_clean_quiet_r4: assert property (@(posedge clk) disable iff (rst)
            (!par_bad && syn == '0) |=> (!dec_single_o && !dec_double_o));
    end else begin : g_comb
        assign enc_code_o   = enc_c;
        assign dec_data_o   = fix_data;
        assign dec_single_o = fix_single;
        assign dec_double_o = fix_double;
        assign dec_pos_o    = fix_pos;
    end

endmodule

// File: tb/secded_codec_tb.sv
module secded_codec_tb_top;

    localparam int DW = 8;
    localparam int R  = 4;
    localparam int CW = 13;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] enc_data_i;
    logic [CW-1:0] enc_code_o;
    logic [CW-1:0] dec_code_i;
    logic [DW-1:0] dec_data_o;
    logic          dec_single_o;
    logic          dec_double_o;
    logic [R-1:0]  dec_pos_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    secded_codec #(.DW(DW), .REG_OUT(1'b1)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .enc_data_i   (enc_data_i),
        .enc_code_o   (enc_code_o),
        .dec_code_i   (dec_code_i),
        .dec_data_o   (dec_data_o),
        .dec_single_o (dec_single_o),
        .dec_double_o (dec_double_o),
        .dec_pos_o    (dec_pos_o)
    );

    // Data positions for DW=8, as stated in R1
    function automatic int pos_of(input int i);
        int tbl [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        return tbl[i];
    endfunction

    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        c = '0;
        for (int i = 0; i < DW; i++) c[pos_of(i)] = d[i];
        for (int k = 0; k < R; k++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW; p++)
                if (((p >> k) & 1) == 1 && p != (1 << k)) x ^= c[p];
            c[1 << k] = x;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] ref_pick(input logic [CW-1:0] c);
        logic [DW-1:0] d;
        for (int i = 0; i < DW; i++) d[i] = c[pos_of(i)];
        return d;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive both halves, let one edge register them, sample at next negedge
    task automatic apply(input logic [DW-1:0] d, input logic [CW-1:0] c);
        @(negedge clk);
        enc_data_i = d;
        dec_code_i = c;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        enc_data_i = 8'hFF;
        dec_code_i = 13'h0003;
        @(negedge clk);
        chk("R10", "reset enc", 32'(enc_code_o), 0);
        chk("R10", "reset data", 32'(dec_data_o), 0);
        chk("R10", "reset flags", {30'd0, dec_single_o, dec_double_o}, 0);
        chk("R10", "reset pos", 32'(dec_pos_o), 0);
        rst = 1'b0;
    endtask

    task automatic t_encode;
        logic [DW-1:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h96};
        foreach (pats[j]) begin
            apply(pats[j], '0);
            chk("R1", "encode word", 32'(enc_code_o), 32'(ref_enc(pats[j])));
            chk("R3", "even weight", 32'(^enc_code_o), 0);
            for (int k = 0; k < R; k++) begin
                logic x;
                x = 1'b0;
                for (int p = 1; p < CW; p++) if (((p >> k) & 1) == 1) x ^= enc_code_o[p];
                chk("R2", "group parity", 32'(x), 0);
            end
        end
    endtask

    task automatic t_walk;
        for (int i = 0; i < DW; i++) begin
            apply(DW'(1) << i, '0);
            chk("R1", "data slot", 32'(enc_code_o[pos_of(i)]), 1);
        end
    endtask

    task automatic t_clean;
        logic [DW-1:0] pats [4] = '{8'h00, 8'hFF, 8'h69, 8'h81};
        foreach (pats[j]) begin
            apply('0, ref_enc(pats[j]));
            chk("R4", "clean data", 32'(dec_data_o), 32'(pats[j]));
            chk("R4", "clean flags", {29'd0, dec_single_o, dec_double_o, |dec_pos_o}, 0);
        end
    endtask

    task automatic t_single;
        logic [CW-1:0] good;
        good = ref_enc(8'hC3);
        for (int p = 1; p < CW; p++) begin
            apply('0, good ^ (CW'(1) << p));
            chk("R5", "single data", 32'(dec_data_o), 32'hC3);
            chk("R5", "single flags", {30'd0, dec_single_o, dec_double_o}, 32'h2);
            chk("R5", "single pos", 32'(dec_pos_o), 32'(p));
        end
    endtask

    task automatic t_bit0;
        apply('0, ref_enc(8'h5E) ^ 13'h0001);
        chk("R6", "bit0 data", 32'(dec_data_o), 32'h5E);
        chk("R6", "bit0 flags", {30'd0, dec_single_o, dec_double_o}, 32'h2);
        chk("R6", "bit0 pos", 32'(dec_pos_o), 0);
    endtask

    task automatic t_double;
        int pa [5] = '{0, 1, 3, 6, 2};
        int pb [5] = '{5, 2, 12, 9, 11};
        logic [CW-1:0] bad;
        foreach (pa[j]) begin
            bad = ref_enc(8'h37) ^ (CW'(1) << pa[j]) ^ (CW'(1) << pb[j]);
            apply('0, bad);
            chk("R7", "double flags", {30'd0, dec_single_o, dec_double_o}, 32'h1);
            chk("R7", "double data", 32'(dec_data_o), 32'(ref_pick(bad)));
            chk("R9", "double pos", 32'(dec_pos_o), 0);
        end
    endtask

    task automatic t_range;
        logic [CW-1:0] bad;
        bad = ref_enc(8'hB4) ^ 13'h0112;  // positions 1, 4, 8: syndrome 13
        apply('0, bad);
        chk("R8", "range flags", {30'd0, dec_single_o, dec_double_o}, 32'h1);
        chk("R8", "range data", 32'(dec_data_o), 32'hB4);
        chk("R8", "range pos", 32'(dec_pos_o), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        enc_data_i = '0;
        dec_code_i = '0;
        t_reset();
        t_encode();
        t_walk();
        t_clean();
        t_single();
        t_bit0();
        t_double();
        t_range();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule